// File: doc/BRIEF.md
# HDLC Bit-Stream Transmitter with Double-Buffered Byte Input

This block turns bytes written by a host into a serial HDLC bit stream for a low-rate signaling channel carried inside an E1 frame. Examples are the common-channel signaling timeslot or the spare national bits of the alignment timeslot. The framer decides which bit positions belong to the channel. It raises a bit-enable strobe once per such position, and the block moves forward by exactly one line bit on every strobe.

While the block is enabled it sends opening/closing flags (`01111110`) without a break. A byte written by the host goes into a holding register. That register is copied into the serializer at a byte boundary, so the host has a full byte time to supply the next byte. An interrupt request stays high whenever the holding register is free. The host marks the final byte of a frame with an end-of-message bit. The block then appends a 16-bit frame check sequence and goes back to flags. It inserts a zero after five consecutive ones inside frame content.

If the host has not supplied the next byte by the time a non-final byte finishes, the frame is aborted. The block sends eight ones, latches an underflow status bit and returns to flags.

Top module: `hdlc_tx_serializer`

## Requirements
- R1: While `enable` is low, `tx_bit` is 1 from the next cycle on and `irq` is 0. After reset `tx_bit` is 1, `irq` is 0 and `uf_flag` is 0.
- R2: When `enable` rises with nothing queued, the stream sends flag octet 0x7E least significant bit first (bit order 0,1,1,1,1,1,1,0), starting with the first strobe, and repeats it for as long as no byte is queued.
- R3: `irq` equals `enable` and holding register empty. A write accepted while `irq` is high makes `irq` low in the next cycle.
- R4: A write that arrives while the holding register is full and is not being moved into the serializer in the same cycle is dropped. The byte already held is kept.
- R5: A frame goes out between flags as the written bytes in write order, each least significant bit first. A new frame starts only at the end of a flag.
- R6: Inside frame content and the check sequence, a 0 is inserted after every run of five 1s. Flags and the abort are never stuffed, so frame content never shows six 1s in a row.
- R7: After the byte written with `wr_eom`=1, the block sends the ones-complement of CRC-16 (polynomial x^16+x^12+x^5+1, preset 0xFFFF, data fed LSB first) low-order bit first. A receiver running the same CRC over content plus check sequence ends at residue 0xF0B8.
- R8: If a non-final byte finishes while the holding register is empty, the block sends 8 ones, sets `uf_flag`, and then resumes flags. No valid frame is delivered.
- R9: `uf_flag` stays set until a `uf_clr` pulse, and is 0 in the cycle after that pulse.
- R10: `tx_bit` changes only in the cycle after a clock edge at which `enable` and `bit_en` were both high.
- R11: Dropping `enable` discards a byte waiting in the holding register. After re-enabling, that byte is never sent.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Transmitter on; low forces mark idle and flushes state |
| bit_en | input | 1 | Framer strobe: one line bit per high cycle |
| wr_valid | input | 1 | Host write strobe for the holding register |
| wr_data | input | 8 | Byte to transmit |
| wr_eom | input | 1 | Marks the written byte as the last of its frame |
| uf_clr | input | 1 | Clears the latched underflow status |
| tx_bit | output | 1 | Serial HDLC line bit |
| irq | output | 1 | Request for the next byte (holding register free) |
| uf_flag | output | 1 | Latched underflow/abort status |

## Verification
The bench decodes the captured line bits as an independent receiver: it removes stuffed zeros, finds flags and aborts, and checks bytes and CRC residue. A design that stuffed flags, missed a stuff bit at a byte or FCS boundary, or sent bytes MSB first would produce no frame, a phantom abort or wrong bytes. The bench goes after a full holding register that receives a second write, which an overwrite bug would turn into an underflow. It also runs a starved frame: the abort and sticky status must appear and must survive until cleared. Finally it disables the block with a byte queued, which a design that keeps stale data would later transmit.

// File: rtl/hdlc_tx_pkg.sv
package hdlc_tx_pkg;
    localparam int BYTE_W     = 8;
    localparam int FCS_W      = 16;
    localparam int STUFF_RUN  = 5;
    localparam logic [BYTE_W-1:0] FLAG_PATTERN  = 8'h7E;
    localparam logic [FCS_W-1:0]  FCS_SEED      = 16'hFFFF;
    localparam logic [FCS_W-1:0]  FCS_POLY_REFL = 16'h8408;

    typedef enum logic [1:0] {
        TX_FLAG,
        TX_DATA,
        TX_FCS,
        TX_ABORT
    } tx_phase_e;

    typedef struct packed {
        logic [BYTE_W-1:0] data;
        logic              eom;
    } tx_word_t;

    // one serial step of the reflected CRC
    function automatic logic [FCS_W-1:0] fcs_step(input logic [FCS_W-1:0] cur,
                                                  input logic din);
        logic fb;
        fb = cur[0] ^ din;
        fcs_step = (cur >> 1) ^ (fb ? FCS_POLY_REFL : '0);
    endfunction
endpackage

// File: rtl/hdlc_tx_holdreg.sv
module hdlc_tx_holdreg
    import hdlc_tx_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     flush,
    input  logic     wr_valid,
    input  tx_word_t wr_word,
    input  logic     take,
    output logic     full,
    output tx_word_t word
);
    always_ff @(posedge clk) begin
        if (rst || flush) begin
            full <= 1'b0;
            word <= '0;
        end else if (wr_valid && (!full || take)) begin
            full <= 1'b1;
            word <= wr_word;
        end else if (take) begin
            full <= 1'b0;
        end
    end
endmodule

// File: rtl/hdlc_tx_fcs.sv
module hdlc_tx_fcs
    import hdlc_tx_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             seed,
    input  logic             feed,
    input  logic             shift,
    input  logic             din,
    output logic [FCS_W-1:0] crc
);
    always_ff @(posedge clk) begin
        if (rst || seed) begin
            crc <= FCS_SEED;
        end else if (feed) begin
            crc <= fcs_step(crc, din);
        end else if (shift) begin
            crc <= {1'b0, crc[FCS_W-1:1]};
        end
    end
endmodule

// File: rtl/hdlc_tx_sticky.sv
module hdlc_tx_sticky (
    input  logic clk,
    input  logic rst,
    input  logic set,
    input  logic clr,
    output logic q
);
    // a new event in the same cycle as a clear wins
    always_ff @(posedge clk) begin
        if (rst) begin
            q <= 1'b0;
        end else if (set) begin
            q <= 1'b1;
        end else if (clr) begin
            q <= 1'b0;
        end
    end
endmodule

// File: rtl/hdlc_tx_serializer.sv
module hdlc_tx_serializer
    import hdlc_tx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              enable,
    input  logic              bit_en,
    input  logic              wr_valid,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic              wr_eom,
    input  logic              uf_clr,
    output logic              tx_bit,
    output logic              irq,
    output logic              uf_flag
);
    localparam int IDX_W     = $clog2(FCS_W);
    localparam int BIT_IDX_W = $clog2(BYTE_W);
    localparam int RUN_W     = $clog2(STUFF_RUN + 1);
    localparam logic [IDX_W-1:0] BYTE_LAST = IDX_W'(BYTE_W - 1);
    localparam logic [IDX_W-1:0] FCS_LAST  = IDX_W'(FCS_W - 1);
    localparam logic [RUN_W-1:0] RUN_TRIP  = RUN_W'(STUFF_RUN - 1);

    tx_phase_e        phase, phase_nxt;
    logic [IDX_W-1:0] idx;
    tx_word_t         cur;
    logic [RUN_W-1:0] run;
    logic             stuff_pend;
    logic             tx_q;

    logic             hold_full;
    tx_word_t         hold_word;
    tx_word_t         wr_word;
    logic [FCS_W-1:0] crc;

    logic step, emit, out_bit, stuffed, last_bit, wrap, take, underflow;
    logic fcs_seed, fcs_feed, fcs_shift;

    assign wr_word = '{data: wr_data, eom: wr_eom};
    assign step    = enable && bit_en;
    assign emit    = step && !stuff_pend;
    assign stuffed = (phase == TX_DATA) || (phase == TX_FCS);

    always_comb begin
        unique case (phase)
            TX_FLAG:  out_bit = FLAG_PATTERN[idx[BIT_IDX_W-1:0]];
            TX_DATA:  out_bit = cur.data[idx[BIT_IDX_W-1:0]];
            TX_FCS:   out_bit = ~crc[0];
            default:  out_bit = 1'b1;
        endcase
    end

    assign last_bit  = (phase == TX_FCS) ? (idx == FCS_LAST) : (idx == BYTE_LAST);
    assign wrap      = emit && last_bit;
    assign take      = wrap && hold_full &&
                       ((phase == TX_FLAG) || (phase == TX_DATA && !cur.eom));
    assign underflow = wrap && (phase == TX_DATA) && !cur.eom && !hold_full;
    assign fcs_seed  = take && (phase == TX_FLAG);
    assign fcs_feed  = emit && (phase == TX_DATA);
    assign fcs_shift = emit && (phase == TX_FCS);

    // phase chosen at the end of each octet (or of the check sequence)
    always_comb begin
        phase_nxt = TX_FLAG;
        unique case (phase)
            TX_FLAG:  phase_nxt = hold_full ? TX_DATA : TX_FLAG;
            TX_DATA:  begin
                if (cur.eom)        phase_nxt = TX_FCS;
                else if (hold_full) phase_nxt = TX_DATA;
                else                phase_nxt = TX_ABORT;
            end
            default:  phase_nxt = TX_FLAG;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst || !enable) begin
            phase      <= TX_FLAG;
            idx        <= '0;
            cur        <= '0;
            run        <= '0;
            stuff_pend <= 1'b0;
            tx_q       <= 1'b1;
        end else if (step) begin
            if (stuff_pend) begin
                tx_q       <= 1'b0;
                stuff_pend <= 1'b0;
                run        <= '0;
            end else begin
                tx_q <= out_bit;
                if (stuffed) begin
                    run        <= out_bit ? run + 1'b1 : '0;
                    stuff_pend <= out_bit && (run == RUN_TRIP);
                end else begin
                    run <= '0;
                end
                if (last_bit) begin
                    idx   <= '0;
                    phase <= phase_nxt;
                    if (take) begin
                        cur <= hold_word;
                    end
                end else begin
                    idx <= idx + 1'b1;
                end
            end
        end
    end

    hdlc_tx_holdreg u_hold (
        .clk      (clk),
        .rst      (rst),
        .flush    (!enable),
        .wr_valid (wr_valid),
        .wr_word  (wr_word),
        .take     (take),
        .full     (hold_full),
        .word     (hold_word)
    );

    hdlc_tx_fcs u_fcs (
        .clk   (clk),
        .rst   (rst || !enable),
        .seed  (fcs_seed),
        .feed  (fcs_feed),
        .shift (fcs_shift),
        .din   (out_bit),
        .crc   (crc)
    );

    hdlc_tx_sticky u_uf (
        .clk (clk),
        .rst (rst),
        .set (underflow),
        .clr (uf_clr),
        .q   (uf_flag)
    );

    assign tx_bit = tx_q;
    assign irq    = enable && !hold_full;
endmodule

// File: rtl/hdlc_tx_checker.sv
module hdlc_tx_checker (
    input logic clk,
    input logic rst,
    input logic enable,
    input logic bit_en,
    input logic wr_valid,
    input logic uf_clr,
    input logic tx_bit,
    input logic irq,
    input logic uf_flag
);
    a_r1_mark_when_off: assert property (@(posedge clk) disable iff (rst)
        !enable |=> tx_bit);

    a_r1_no_irq_when_off: assert property (@(posedge clk) disable iff (rst)
        !enable |-> !irq);

    a_r3_write_fills: assert property (@(posedge clk) disable iff (rst)
        (irq && wr_valid) |=> !irq);

    a_r9_status_sticky: assert property (@(posedge clk) disable iff (rst)
        (uf_flag && !uf_clr) |=> uf_flag);

    a_r10_hold_without_strobe: assert property (@(posedge clk) disable iff (rst)
        (enable && !bit_en) |=> $stable(tx_bit));
endmodule

bind hdlc_tx_serializer hdlc_tx_checker chk_i (
    .clk      (clk),
    .rst      (rst),
    .enable   (enable),
    .bit_en   (bit_en),
    .wr_valid (wr_valid),
    .uf_clr   (uf_clr),
    .tx_bit   (tx_bit),
    .irq      (irq),
    .uf_flag  (uf_flag)
);

// File: tb/hdlc_tx_serializer_tb_top.sv
module hdlc_tx_serializer_tb_top;
    localparam int CLK_PERIOD      = 10;
    localparam int WATCHDOG_CYCLES = 150000;
    localparam int WAIT_LIMIT      = 20000;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       enable = 1'b0;
    logic       bit_en = 1'b0;
    logic       wr_valid = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       wr_eom = 1'b0;
    logic       uf_clr = 1'b0;
    logic       tx_bit, irq, uf_flag;

    int checks = 0;
    int errors = 0;
    int strobe_mode = 0;   // 0 off, 1 every cycle, 2 random

    hdlc_tx_serializer dut_i (
        .clk(clk), .rst(rst), .enable(enable), .bit_en(bit_en),
        .wr_valid(wr_valid), .wr_data(wr_data), .wr_eom(wr_eom),
        .uf_clr(uf_clr), .tx_bit(tx_bit), .irq(irq), .uf_flag(uf_flag)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    initial begin
        forever begin
            @(negedge clk);
            case (strobe_mode)
                1:       bit_en = 1'b1;
                2:       bit_en = 1'($urandom % 2);
                default: bit_en = 1'b0;
            endcase
        end
    end

    // ---------------- receiver model ----------------
    logic        en_q = 1'b0, on_q = 1'b0, prev_tx = 1'b1;
    int          stab_viol = 0;
    bit          capq[$];
    bit          dbits[$];
    int          ones_run = 0;
    byte unsigned last_frame[$];
    byte unsigned pay[$];
    int          frames_seen = 0;
    int          aborts_seen = 0;

    task automatic feed_bit(input bit b);
        if (!b && ones_run == 5) begin
            ones_run = 0;
            return;
        end
        if (b) begin
            ones_run++;
            dbits.push_back(1'b1);
            return;
        end
        if (ones_run >= 7) begin
            aborts_seen++;
            dbits.delete();
        end else if (ones_run == 6) begin
            int n;
            n = dbits.size() - 7;
            if (n >= 24 && n % 8 == 0) begin
                last_frame.delete();
                for (int i = 0; i < n / 8; i++) begin
                    byte unsigned v;
                    v = 0;
                    for (int k = 0; k < 8; k++) v[k] = dbits[i*8 + k];
                    last_frame.push_back(v);
                end
                frames_seen++;
            end
            dbits.delete();
        end else begin
            dbits.push_back(1'b0);
        end
        ones_run = 0;
    endtask

    always @(posedge clk) begin
        en_q <= enable && bit_en;
        on_q <= enable;
    end

    always @(negedge clk) begin
        if (!rst) begin
            if (on_q && !en_q && tx_bit != prev_tx) stab_viol++;
            if (en_q) begin
                capq.push_back(tx_bit);
                feed_bit(tx_bit);
            end
        end
        prev_tx = tx_bit;
    end

    // ---------------- helpers ----------------
    function automatic logic [15:0] residue();
        logic [15:0] c;
        c = 16'hFFFF;
        foreach (last_frame[i]) begin
            for (int k = 0; k < 8; k++) begin
                logic x;
                x = c[0] ^ last_frame[i][k];
                c = c >> 1;
                if (x) c = c ^ 16'h8408;
            end
        end
        return c;
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic host_write(input byte unsigned d, input bit eom, input bit wait_irq);
        if (wait_irq) begin
            int t;
            t = 0;
            while (!irq && t < WAIT_LIMIT) begin
                @(negedge clk);
                t++;
            end
        end
        wr_valid = 1'b1;
        wr_data  = d;
        wr_eom   = eom;
        @(negedge clk);
        wr_valid = 1'b0;
        wr_eom   = 1'b0;
    endtask

    task automatic wait_frames(input int target);
        int t;
        t = 0;
        while (frames_seen < target && t < WAIT_LIMIT) begin
            @(negedge clk);
            t++;
        end
    endtask

    task automatic send_and_check(input string tag);
        int base, bad;
        base = frames_seen;
        foreach (pay[i]) host_write(pay[i], i == pay.size() - 1, 1'b1);
        wait_frames(base + 1);
        check(frames_seen == base + 1, "R5", {tag, " frame delimited"}, frames_seen, base + 1);
        check(last_frame.size() == pay.size() + 2, "R5", {tag, " length"},
              last_frame.size(), pay.size() + 2);
        bad = 0;
        foreach (pay[i]) if (i < last_frame.size() && last_frame[i] != pay[i]) bad++;
        check(bad == 0, "R5", {tag, " bytes mismatching"}, bad, 0);
        check(residue() == 16'hF0B8, "R7", {tag, " crc residue"}, residue(), 16'hF0B8);
    endtask

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (WATCHDOG_CYCLES) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    // ---------------- main sequence ----------------
    initial begin
        int base, ab_base, len;
        void'($urandom(32'h1DEA5));
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        check(tx_bit == 1'b1, "R1", "tx after reset", tx_bit, 1);
        check(irq == 1'b0, "R1", "irq after reset", irq, 0);
        check(uf_flag == 1'b0, "R9", "status after reset", uf_flag, 0);

        // R2 idle flags from enable
        strobe_mode = 1;
        @(negedge clk);
        capq.delete();
        enable = 1'b1;
        while (capq.size() < 24) @(negedge clk);
        begin
            int bad;
            bad = 0;
            for (int i = 0; i < 24; i++) if (capq[i] != 1'(8'h7E >> (i % 8))) bad++;
            check(bad == 0, "R2", "idle flag bits wrong", bad, 0);
        end
        check(irq == 1'b1, "R3", "irq with empty holding", irq, 1);

        // R3 / R4 with the line paused
        strobe_mode = 0;
        repeat (2) @(negedge clk);
        host_write(8'hA5, 1'b1, 1'b0);
        check(irq == 1'b0, "R3", "irq after write", irq, 0);
        host_write(8'h3C, 1'b0, 1'b0);
        check(irq == 1'b0, "R4", "irq while full", irq, 0);
        strobe_mode = 2;
        base = frames_seen;
        ab_base = aborts_seen;
        wait_frames(base + 1);
        check(frames_seen == base + 1 && last_frame.size() == 3 && last_frame[0] == 8'hA5,
              "R4", "first byte kept", last_frame.size() > 0 ? last_frame[0] : -1, 8'hA5);
        check(irq == 1'b1, "R3", "irq after frame drained", irq, 1);

        // R5 / R6 / R7 frames
        for (int f = 0; f < 7; f++) begin
            pay.delete();
            len = 1 + int'($urandom % 6);
            for (int i = 0; i < len; i++) begin
                if (f == 2)      pay.push_back(8'hFF);
                else if (f == 3) pay.push_back((i % 2) ? 8'hF8 : 8'h1F);
                else             pay.push_back(8'($urandom));
            end
            strobe_mode = (f == 4) ? 1 : 2;
            send_and_check((f == 2) ? "R6 all-ones" : "random");
        end
        check(aborts_seen == ab_base, "R6", "no abort in stuffed frames", aborts_seen, ab_base);

        // R8 / R9 underflow
        strobe_mode = 2;
        base = frames_seen;
        ab_base = aborts_seen;
        host_write(8'h5A, 1'b0, 1'b1);
        begin
            int t;
            t = 0;
            while (aborts_seen == ab_base && t < WAIT_LIMIT) begin
                @(negedge clk);
                t++;
            end
        end
        check(aborts_seen == ab_base + 1, "R8", "abort seen", aborts_seen, ab_base + 1);
        check(uf_flag == 1'b1, "R8", "underflow status", uf_flag, 1);
        check(frames_seen == base, "R8", "no frame delivered", frames_seen, base);
        repeat (100) @(negedge clk);
        check(uf_flag == 1'b1, "R9", "status held", uf_flag, 1);
        uf_clr = 1'b1;
        @(negedge clk);
        uf_clr = 1'b0;
        check(uf_flag == 1'b0, "R9", "status cleared", uf_flag, 0);
        pay.delete();
        pay.push_back(8'h81);
        pay.push_back(8'h7E);
        send_and_check("R8 recovery");

        // R11 / R1 disable flushes queue
        strobe_mode = 0;
        repeat (2) @(negedge clk);
        base = frames_seen;
        host_write(8'h11, 1'b1, 1'b0);
        enable = 1'b0;
        @(negedge clk);
        check(tx_bit == 1'b1, "R1", "tx while disabled", tx_bit, 1);
        check(irq == 1'b0, "R1", "irq while disabled", irq, 0);
        enable = 1'b1;
        strobe_mode = 2;
        @(negedge clk);
        check(irq == 1'b1, "R11", "holding flushed", irq, 1);
        repeat (300) @(negedge clk);
        check(frames_seen == base, "R11", "flushed byte not sent", frames_seen, base);

        check(stab_viol == 0, "R10", "tx changed without strobe", stab_viol, 0);
        finish_run();
    end
endmodule